// File: doc/BRIEF.md
# Banked Work RAM Controller

This block is a byte-wide work RAM sitting behind a 16-bit CPU address. The region 0xC000–0xCFFF is a fixed window that always reaches the first 4 KB slice of the storage. The region 0xD000–0xDFFF is a switchable window whose slice is picked by a 3-bit bank register at 0xFF70. The region 0xE000–0xFDFF is an echo of the two windows: address bit 12 picks the slice directly and the bank register plays no part.

A mode input picks between a small mono layout and a large colour layout. In mono mode only two slices exist (8 KB), and the switchable window is fixed to slice one. In colour mode eight slices exist (32 KB), and the switchable window follows the bank register. A bank value of zero is never stored; it becomes one. Reads return data one clock after the request, and writes land on the clock edge where the access is strobed.

The slice size is set by the parameter `WIN_ABITS`. A full-size build uses 12, which gives 4 KB slices. The default of 8 keeps the array small. With a smaller value, the unused upper offset bits inside each 4 KB window alias onto the same bytes.

Top module: `wram_banker`

## Requirements
- R1: After reset, a read of 0xFF70 returns 0x01 and the read data output is 0x00 until the first read completes.
- R2: An access in 0xC000–0xCFFF reaches slice 0 at offset addr[WIN_ABITS-1:0], in both modes.
- R3: In colour mode (colorMode=1), an access in 0xD000–0xDFFF reaches slice bank at offset addr[WIN_ABITS-1:0], which is array index bank*2^WIN_ABITS + offset.
- R4: A write to 0xFF70 stores data[2:0] as the bank and ignores data[7:3]. A written field of 0 stores 1 instead. No other access changes the bank.
- R5: A read of 0xFF70 returns the bank in bits [2:0], with bits [7:3] zero, in either mode.
- R6: An access in 0xE000–0xFDFF reaches slice addr[12] at offset addr[WIN_ABITS-1:0], whatever the bank.
- R7: In mono mode (colorMode=0), 0xD000–0xDFFF always reaches slice 1, and the bank register has no effect on mapping.
- R8: Read data appears on cpuRdData one clock after a strobed read (cpuSel=1, cpuWe=0). It holds its value through idle cycles and through write cycles.
- R9: Unmapped addresses behave as empty space. This covers 0x0000–0xBFFF, 0xFE00–0xFFFF except 0xFF70, and any cycle with cpuSel=0. A read of an unmapped address returns 0x00, and a write to one changes no stored byte.
- R10: Address bits [11:WIN_ABITS] inside a window do not take part in the offset. Two addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colorMode | input | 1 | 1 selects the eight-slice colour layout; 0 selects the two-slice mono layout |
| cpuSel | input | 1 | Access strobe for this cycle |
| cpuWe | input | 1 | 1 = write, 0 = read, when cpuSel is high |
| cpuAddr | input | 16 | CPU byte address |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data, valid the cycle after a read |

## Verification
The bench fills every slice through the switchable window and then reads each one back using different upper offset bits. A design that computed the slice offset wrongly, or used too many offset bits, would return another slice's pattern. It then checks the zero-to-one bank substitution and that the bank field ignores data[7:3]. A register that stored the raw field would read back 0 or leak the high bits. The echo region is read while a non-default bank is selected, so a decoder that applied the bank there would return the wrong slice. Writes to 0xFE00 and unselected writes are checked against the bytes they would hit if decoded wrongly. Mono mode is checked with a bank other than 1 held in the register, so any leak of the bank into mono mapping shows up.

// File: rtl/wram_pkg.sv
package wram_pkg;

  localparam int BANK_W = 3;
  localparam logic [15:0] BANK_REG_ADDR = 16'hFF70;

  typedef struct packed {
    logic memWr;
    logic memRd;
    logic bankRd;
    logic zeroRd;
  } wramStrobe_t;

endpackage

// File: rtl/wram_ctrl.sv
module wram_ctrl
  import wram_pkg::*;
#(
  parameter int WIN_ABITS = 8,
  localparam int AW = WIN_ABITS + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colorMode,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [15:0]       cpuAddr,
  input  logic [BANK_W-1:0] bankWrData,
  output wramStrobe_t       strobes,
  output logic [AW-1:0]     memAddr,
  output logic [BANK_W-1:0] bankOut
);

  logic inLow, inHigh, inMirror, isBankReg, memHit;
  logic [BANK_W-1:0] bankQ;
  logic [BANK_W-1:0] winIdx;
  logic bankWr;

  always_comb begin
    inLow     = (cpuAddr[15:12] == 4'hC);
    inHigh    = (cpuAddr[15:12] == 4'hD);
    inMirror  = (cpuAddr[15:13] == 3'b111) && (cpuAddr[15:9] != 7'h7F);
    isBankReg = (cpuAddr == BANK_REG_ADDR);
    memHit    = inLow || inHigh || inMirror;
  end

  always_comb begin
    winIdx = '0;
    if (inHigh) begin
      winIdx = colorMode ? bankQ : BANK_W'(1);
    end else if (inMirror) begin
      winIdx = BANK_W'(cpuAddr[12]);
    end
  end

  assign memAddr = {winIdx, cpuAddr[WIN_ABITS-1:0]};

  always_comb begin
    strobes.memWr  = cpuSel && cpuWe && memHit;
    strobes.memRd  = cpuSel && !cpuWe && memHit;
    strobes.bankRd = cpuSel && !cpuWe && isBankReg;
    strobes.zeroRd = cpuSel && !cpuWe && !memHit && !isBankReg;
  end

  assign bankWr = cpuSel && cpuWe && isBankReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= BANK_W'(1);
    end else if (bankWr) begin
      bankQ <= (bankWrData == '0) ? BANK_W'(1) : bankWrData;
    end
  end

  assign bankOut = bankQ;

  assert_bank_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bankWr && bankWrData != '0) |=> (bankOut == $past(bankWrData)));

  assert_bank_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bankWr && bankWrData == '0) |=> (bankOut == BANK_W'(1)));

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !bankWr |=> $stable(bankOut));

  assert_mono_slice_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!colorMode && (strobes.memRd || strobes.memWr)) |-> (memAddr[AW-1:WIN_ABITS+1] == '0));

endmodule

// File: rtl/wram_datapath.sv
module wram_datapath
  import wram_pkg::*;
#(
  parameter int WIN_ABITS = 8,
  localparam int AW = WIN_ABITS + BANK_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  wramStrobe_t       strobes,
  input  logic [AW-1:0]     memAddr,
  input  logic [7:0]        wrData,
  input  logic [BANK_W-1:0] bankVal,
  output logic [7:0]        rdData
);

  logic [7:0] memArr [DEPTH];
  logic [7:0] rdQ;

  always_ff @(posedge clk) begin
    if (strobes.memWr) begin
      memArr[memAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobes.memRd) begin
      rdQ <= memArr[memAddr];
    end else if (strobes.bankRd) begin
      rdQ <= {{(8-BANK_W){1'b0}}, bankVal};
    end else if (strobes.zeroRd) begin
      rdQ <= '0;
    end
  end

  assign rdData = rdQ;

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.memWr, strobes.memRd, strobes.bankRd, strobes.zeroRd}));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.memRd || strobes.bankRd || strobes.zeroRd) |=> $stable(rdData));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroRd |=> (rdData == 8'h00));

  assert_bank_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bankRd |=> (rdData == {{(8-BANK_W){1'b0}}, $past(bankVal)}));

endmodule

// File: rtl/wram_banker.sv
module wram_banker
  import wram_pkg::*;
#(
  parameter int WIN_ABITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        colorMode,
  input  logic        cpuSel,
  input  logic        cpuWe,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData
);

  localparam int AW = WIN_ABITS + BANK_W;

  wramStrobe_t       strobes;
  logic [AW-1:0]     memAddr;
  logic [BANK_W-1:0] bankVal;

  wram_ctrl #(.WIN_ABITS(WIN_ABITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .colorMode  (colorMode),
    .cpuSel     (cpuSel),
    .cpuWe      (cpuWe),
    .cpuAddr    (cpuAddr),
    .bankWrData (cpuWrData[BANK_W-1:0]),
    .strobes    (strobes),
    .memAddr    (memAddr),
    .bankOut    (bankVal)
  );

  wram_datapath #(.WIN_ABITS(WIN_ABITS)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .memAddr (memAddr),
    .wrData  (cpuWrData),
    .bankVal (bankVal),
    .rdData  (cpuRdData)
  );

endmodule

// File: tb/wram_banker_bench.sv
`timescale 1ns/1ps
module wram_banker_bench;

  localparam int WA = 8;
  localparam int WSIZE = 1 << WA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colorMode = 1'b1;
  logic        cpuSel = 1'b0;
  logic        cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int bankModel = 1;
  logic [7:0] mdl [8*WSIZE];

  wram_banker #(.WIN_ABITS(WA)) u_wram_banker (
    .clk(clk), .rstN(rstN), .colorMode(colorMode), .cpuSel(cpuSel),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int w, int o);
    return 8'((w * 37 + o * 13 + 5) ^ (o >> 3));
  endfunction

  function automatic int mapIdx(logic [15:0] a);
    int off;
    off = int'(a) % WSIZE;
    if (a[15:12] == 4'hC) return off;
    if (a[15:12] == 4'hD) return (colorMode ? bankModel : 1) * WSIZE + off;
    if (a >= 16'hE000 && a < 16'hFE00) return int'(a[12]) * WSIZE + off;
    return -1;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d, bit sel = 1);
    int idx;
    @(negedge clk);
    cpuSel = sel; cpuWe = 1'b1; cpuAddr = a; cpuWrData = d;
    if (sel) begin
      idx = mapIdx(a);
      if (idx >= 0) mdl[idx] = d;
      else if (a == 16'hFF70) bankModel = (d[2:0] == 3'd0) ? 1 : int'(d[2:0]);
    end
    @(negedge clk);
    cpuSel = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doRead(logic [15:0] a, string req);
    int idx;
    logic [7:0] exp;
    idx = mapIdx(a);
    if (idx >= 0) exp = mdl[idx];
    else if (a == 16'hFF70) exp = 8'(bankModel);
    else exp = 8'h00;
    @(negedge clk);
    cpuSel = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    @(negedge clk);
    cpuSel = 1'b0;
    check(req, cpuRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", cpuRdData, 8'h00);
    doRead(16'hFF70, "R1");

    // fill slice 0 via fixed window (R2)
    for (int o = 0; o < WSIZE; o++) doWrite(16'hC000 + 16'(o), pat(0, o));
    // fill slices 1..7 via switchable window, junk in data[7:3] (R4), aliased offsets (R10)
    for (int b = 1; b < 8; b++) begin
      doWrite(16'hFF70, 8'(b) | 8'hF8);
      doRead(16'hFF70, "R4");
      for (int o = 0; o < WSIZE; o++)
        doWrite(16'hD000 + 16'((b << 8) | o), pat(b, o));
    end

    // R2 readback with different upper offset bits (R10)
    for (int o = 0; o < WSIZE; o++) begin
      check("R2", 8'h00, 8'h00);
      total--;
      doRead(16'hC000 + 16'(12'h300 | o), "R2");
    end
    // R3 readback per bank, aliased differently (R10)
    for (int b = 1; b < 8; b++) begin
      doWrite(16'hFF70, 8'(b));
      for (int o = 0; o < WSIZE; o++) begin
        doRead(16'hD000 + 16'((((b + 3) & 7) << 8) | o), "R3");
        check("R10", mdl[b * WSIZE + o], pat(b, o));
      end
    end

    // R4: zero field becomes one
    doWrite(16'hFF70, 8'h08);
    doRead(16'hFF70, "R4");
    check("R4", 8'(bankModel), 8'h01);
    doRead(16'hD005, "R4");
    check("R4", cpuRdData, pat(1, 5));

    // R6: echo region with a non-default bank selected
    doWrite(16'hFF70, 8'h05);
    doRead(16'hFF70, "R5");
    for (int o = 0; o < WSIZE; o++) begin
      doRead(16'hE000 + 16'(o), "R6");
      doRead(16'hF000 + 16'(o), "R6");
    end
    doRead(16'hFDFF, "R6");
    doWrite(16'hE123, 8'h5A);
    doRead(16'hC023, "R6");

    // R9: unmapped reads and writes
    doRead(16'hFE00, "R9");
    doRead(16'hFF71, "R9");
    doRead(16'hA000, "R9");
    doRead(16'h0000, "R9");
    doWrite(16'hFE00, 8'hAA);
    doWrite(16'hBF00, 8'hAB);
    doRead(16'hF000, "R9");
    doRead(16'hDF00, "R9");
    doWrite(16'hD010, 8'hCC, 0);
    doRead(16'hD010, "R9");
    doWrite(16'hFF70, 8'h02, 0);
    doRead(16'hFF70, "R9");

    // R8: hold through idle and write cycles
    doRead(16'hC044, "R8");
    held = cpuRdData;
    repeat (3) @(negedge clk);
    check("R8", cpuRdData, held);
    doWrite(16'hC044, 8'h11);
    check("R8", cpuRdData, held);
    doRead(16'hC044, "R8");

    // R7: mono mode with bank 6 held
    doWrite(16'hFF70, 8'h06);
    colorMode = 1'b0;
    doRead(16'hFF70, "R5");
    for (int o = 0; o < WSIZE; o++) doRead(16'hD000 + 16'(o), "R7");
    doWrite(16'hD077, 8'h3C);
    colorMode = 1'b1;
    doWrite(16'hFF70, 8'h01);
    doRead(16'hD077, "R7");
    check("R7", cpuRdData, 8'h3C);
    doWrite(16'hFF70, 8'h06);
    doRead(16'hD077, "R7");
    check("R7", cpuRdData, pat(6, 8'h77));

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule